// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block chooses one reference from five candidate clock inputs, numbered 1 to 5. Each candidate arrives with a ready-made qualification flag and a 4-bit priority code. A candidate is usable only when its flag is set and its priority code is nonzero. A smaller nonzero code ranks higher, and when codes are equal the lower input number wins. The block does not look at clock activity or frequency. It works only on these flags and codes.

Every clock cycle the block registers two results. The first is the index of the selected input. The second is a ranked list of the three best usable candidates. The mode input sets how switching works. In revertive mode the selection always tracks the best usable candidate. In non-revertive mode the selection stays on the current input for as long as that input stays usable, and it moves to the best candidate only when the current one is lost. When no candidate is usable, a sticky failure bit is set. That bit drives an interrupt, subject to an enable input, and a write-one-to-clear pulse clears it.

Top module: `refsel_top`

## Requirements
- R1: A candidate k (1 to 5) is usable only when `qual_i[k-1]` is 1 and its priority field `prio_i[4k-1:4k-4]` is nonzero. A field of 0 keeps that input out of both the selection and the ranking. Among usable inputs, a numerically smaller priority code ranks higher.
- R2: When usable inputs have equal priority codes, the one with the lower index ranks higher and is chosen first.
- R3: `rank_o[3:0]`, `rank_o[7:4]` and `rank_o[11:8]` hold the 1-based indices of the best, second and third usable inputs. A slot with no usable candidate reads 0.
- R4: With `revert_i`=1, the selected index equals the best usable index.
- R5: With `revert_i`=0, the selection does not change while the current input stays usable, even if a higher-ranked input becomes usable.
- R6: With `revert_i`=0, when the current input stops being usable (flag cleared or priority set to 0), the selection moves to the best usable input.
- R7: When no input is usable, the selected index reads 0.
- R8: `fail_o` is set at the clock edge that follows any cycle in which no input is usable. It then stays set until a cycle with `fail_clr_i`=1 in which some input is usable. If setting and clearing happen in the same cycle, setting wins.
- R9: `irq_o` is 1 exactly when `fail_o` is 1 and `irq_en_i` is 1.
- R10: `sel_o`, `rank_o` and `fail_o` are registered and reflect the inputs of the preceding clock cycle. A synchronous active-high `rst` clears all three to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qual_i | input | 5 | Qualification flag per input; bit k-1 belongs to input k |
| prio_i | input | 20 | Four-bit priority code per input; 0 disables the input |
| revert_i | input | 1 | 1 selects revertive mode, 0 selects non-revertive mode |
| irq_en_i | input | 1 | Interrupt enable |
| fail_clr_i | input | 1 | Write-one-to-clear pulse for the failure bit |
| sel_o | output | 4 | Selected input index, 0 when none |
| rank_o | output | 12 | Three ranked candidate indices, best in the low nibble |
| fail_o | output | 1 | Sticky failure bit: no input was usable |
| irq_o | output | 1 | Interrupt request |

## Verification
Selection, ranking and the failure bit each take exactly one clock edge after their inputs change. The bench therefore drives every input pattern on the falling edge, lets one rising edge pass, and samples on the next falling edge. Before that edge it computes the expected selection, ranking and failure state from the inputs it just drove, using its own model. The interrupt follows the enable without any delay, so the bench checks it in the same sample right after the enable changes.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned DEF_NUM_IN = 5;
  localparam int unsigned DEF_PRIO_W = 4;
  localparam int unsigned DEF_IDX_W  = 4;
  localparam int unsigned DEF_RANK_N = 3;

  typedef enum logic {MODE_HOLD = 1'b0, MODE_REVERT = 1'b1} sel_mode_e;
endpackage

// File: rtl/refsel_elig.sv
module refsel_elig #(
  parameter int unsigned NUM_IN = refsel_pkg::DEF_NUM_IN,
  parameter int unsigned PRIO_W = refsel_pkg::DEF_PRIO_W
) (
  input  logic [NUM_IN-1:0]        qual,
  input  logic [NUM_IN*PRIO_W-1:0] prio,
  output logic [NUM_IN-1:0]        usable
);
  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    // priority code zero parks the input
    assign usable[g] = qual[g] && (prio[g*PRIO_W +: PRIO_W] != '0);
  end
endmodule

// File: rtl/refsel_rank.sv
module refsel_rank #(
  parameter int unsigned NUM_IN = refsel_pkg::DEF_NUM_IN,
  parameter int unsigned PRIO_W = refsel_pkg::DEF_PRIO_W,
  parameter int unsigned IDX_W  = refsel_pkg::DEF_IDX_W,
  parameter int unsigned RANK_N = refsel_pkg::DEF_RANK_N
) (
  input  logic [NUM_IN-1:0]        usable,
  input  logic [NUM_IN*PRIO_W-1:0] prio,
  output logic [RANK_N*IDX_W-1:0]  ranks
);
  // Best member of a mask: smallest code, lowest index on a tie; 0 if empty.
  function automatic logic [IDX_W-1:0] best_of(input logic [NUM_IN-1:0] mask,
                                               input logic [NUM_IN*PRIO_W-1:0] p);
    logic [IDX_W-1:0]  win;
    logic [PRIO_W-1:0] win_p;
    win   = '0;
    win_p = '1;
    for (int i = 0; i < NUM_IN; i++) begin
      if (mask[i] && ((win == '0) || (p[i*PRIO_W +: PRIO_W] < win_p))) begin
        win   = IDX_W'(i + 1);
        win_p = p[i*PRIO_W +: PRIO_W];
      end
    end
    return win;
  endfunction

  function automatic logic [NUM_IN-1:0] drop(input logic [NUM_IN-1:0] mask,
                                             input logic [IDX_W-1:0] idx);
    logic [NUM_IN-1:0] m;
    m = mask;
    for (int i = 0; i < NUM_IN; i++) begin
      if (idx == IDX_W'(i + 1)) m[i] = 1'b0;
    end
    return m;
  endfunction

  logic [NUM_IN-1:0] remain [RANK_N+1];
  assign remain[0] = usable;

  for (genvar s = 0; s < RANK_N; s++) begin : g_slot
    logic [IDX_W-1:0] pick;
    assign pick                      = best_of(remain[s], prio);
    assign ranks[s*IDX_W +: IDX_W]   = pick;
    assign remain[s+1]               = drop(remain[s], pick);
  end
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick #(
  parameter int unsigned NUM_IN = refsel_pkg::DEF_NUM_IN,
  parameter int unsigned IDX_W  = refsel_pkg::DEF_IDX_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  refsel_pkg::sel_mode_e    mode,
  input  logic [NUM_IN-1:0]        usable,
  input  logic [IDX_W-1:0]         best,
  output logic [IDX_W-1:0]         sel_q,
  output logic                     cur_live
);
  function automatic logic live_at(input logic [IDX_W-1:0] idx,
                                   input logic [NUM_IN-1:0] u);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (idx == IDX_W'(i + 1)) hit = u[i];
    end
    return hit;
  endfunction

  logic [IDX_W-1:0] sel_d;

  assign cur_live = live_at(sel_q, usable);

  always_comb begin
    if (mode == refsel_pkg::MODE_REVERT) sel_d = best;
    else if (cur_live)                   sel_d = sel_q;
    else                                 sel_d = best;
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_d;
  end
endmodule

// File: rtl/refsel_alarm.sv
module refsel_alarm (
  input  logic clk,
  input  logic rst,
  input  logic none_live,
  input  logic clr,
  input  logic en,
  output logic fail_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) fail_q <= 1'b0;
    else     fail_q <= none_live | (fail_q & ~clr);
  end
  assign irq = fail_q & en;
endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
  parameter int unsigned NUM_IN = refsel_pkg::DEF_NUM_IN,
  parameter int unsigned PRIO_W = refsel_pkg::DEF_PRIO_W,
  parameter int unsigned IDX_W  = refsel_pkg::DEF_IDX_W,
  parameter int unsigned RANK_N = refsel_pkg::DEF_RANK_N
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        qual_i,
  input  logic [NUM_IN*PRIO_W-1:0] prio_i,
  input  logic                     revert_i,
  input  logic                     irq_en_i,
  input  logic                     fail_clr_i,
  output logic [IDX_W-1:0]         sel_o,
  output logic [RANK_N*IDX_W-1:0]  rank_o,
  output logic                     fail_o,
  output logic                     irq_o
);
  localparam int unsigned RANK_W = RANK_N * IDX_W;

  initial begin
    if ((1 << IDX_W) <= NUM_IN) $error("IDX_W too narrow for NUM_IN");
  end

  logic [NUM_IN-1:0]     usable_w;
  logic [RANK_W-1:0]     rank_d;
  logic [RANK_W-1:0]     rank_q;
  logic                  none_live_w;
  logic                  cur_live_w;
  refsel_pkg::sel_mode_e mode_w;

  assign mode_w      = refsel_pkg::sel_mode_e'(revert_i);
  assign none_live_w = (usable_w == '0);

  refsel_elig #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W)) elig_i (
    .qual(qual_i), .prio(prio_i), .usable(usable_w));

  refsel_rank #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .RANK_N(RANK_N)) rank_i (
    .usable(usable_w), .prio(prio_i), .ranks(rank_d));

  refsel_pick #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) pick_i (
    .clk(clk), .rst(rst), .mode(mode_w), .usable(usable_w),
    .best(rank_d[IDX_W-1:0]), .sel_q(sel_o), .cur_live(cur_live_w));

  refsel_alarm alarm_i (
    .clk(clk), .rst(rst), .none_live(none_live_w), .clr(fail_clr_i),
    .en(irq_en_i), .fail_q(fail_o), .irq(irq_o));

  always_ff @(posedge clk) begin
    if (rst) rank_q <= '0;
    else     rank_q <= rank_d;
  end
  assign rank_o = rank_q;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk #(
  parameter int unsigned NUM_IN = refsel_pkg::DEF_NUM_IN,
  parameter int unsigned PRIO_W = refsel_pkg::DEF_PRIO_W,
  parameter int unsigned IDX_W  = refsel_pkg::DEF_IDX_W,
  parameter int unsigned RANK_N = refsel_pkg::DEF_RANK_N
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_IN-1:0]        qual_i,
  input logic [NUM_IN*PRIO_W-1:0] prio_i,
  input logic                     revert_i,
  input logic                     irq_en_i,
  input logic                     fail_clr_i,
  input logic [IDX_W-1:0]         sel_o,
  input logic [RANK_N*IDX_W-1:0]  rank_o,
  input logic                     fail_o,
  input logic                     irq_o
);
  logic [NUM_IN-1:0] live_c;
  logic              sel_live_c;

  always_comb begin
    sel_live_c = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      live_c[i] = qual_i[i] && (prio_i[i*PRIO_W +: PRIO_W] != '0);
      if (sel_o == IDX_W'(i + 1)) sel_live_c = live_c[i];
    end
  end

  a_r4_revert_tracks: assert property (@(posedge clk) disable iff (rst)
    revert_i |=> (sel_o == rank_o[IDX_W-1:0]));

  a_r5_hold_current: assert property (@(posedge clk) disable iff (rst)
    (!revert_i && sel_live_c) |=> $stable(sel_o));

  a_r7_empty_matches: assert property (@(posedge clk) disable iff (rst)
    (sel_o == '0) == (rank_o[IDX_W-1:0] == '0));

  a_r8_sets: assert property (@(posedge clk) disable iff (rst)
    (live_c == '0) |=> fail_o);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !fail_clr_i) |=> fail_o);

  a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
    !fail_o |-> !irq_o);

  for (genvar s = 1; s < RANK_N; s++) begin : g_gap
    a_r3_no_gap: assert property (@(posedge clk) disable iff (rst)
      (rank_o[(s-1)*IDX_W +: IDX_W] == '0) |-> (rank_o[s*IDX_W +: IDX_W] == '0));
  end
endmodule

bind refsel_top refsel_chk #(
  .NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .RANK_N(RANK_N)) chk_i (.*);

// File: tb/refsel_tb.sv
module refsel_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  qual_i;
  logic [19:0] prio_i;
  logic        revert_i, irq_en_i, fail_clr_i;
  logic [3:0]  sel_o;
  logic [11:0] rank_o;
  logic        fail_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] m_sel;
  logic       m_fail;

  always #4 clk = ~clk;

  refsel_top dut_i (.*);

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit live(int k);
    return qual_i[k] && (prio_i[k*4 +: 4] != 4'd0);
  endfunction

  // n-th best (0-based) usable input via key ordering; 0 if none
  function automatic int nth_best(int n);
    int res = 0;
    for (int k = 0; k < 5; k++) begin
      int below = 0;
      if (!live(k)) continue;
      for (int j = 0; j < 5; j++)
        if (live(j) && ((prio_i[j*4 +: 4] * 8 + j) < (prio_i[k*4 +: 4] * 8 + k))) below++;
      if (below == n) res = k + 1;
    end
    return res;
  endfunction

  // model one clock edge and compare registered outputs
  task automatic step(string tag);
    int r0, r1, r2;
    bit any;
    r0 = nth_best(0); r1 = nth_best(1); r2 = nth_best(2);
    any = (r0 != 0);
    if (revert_i) m_sel = 4'(r0);
    else if (!(m_sel != 0 && live(int'(m_sel) - 1))) m_sel = 4'(r0);
    m_fail = !any || (m_fail && !fail_clr_i);
    @(posedge clk); @(negedge clk);
    check(tag, "sel", int'(sel_o), int'(m_sel));
    check(tag, "rank1", int'(rank_o[3:0]), r0);
    check(tag, "rank2", int'(rank_o[7:4]), r1);
    check(tag, "rank3", int'(rank_o[11:8]), r2);
    check(tag, "fail", int'(fail_o), int'(m_fail));
    check(tag, "irq", int'(irq_o), int'(m_fail && irq_en_i));
  endtask

  function automatic logic [19:0] pk(int p1, int p2, int p3, int p4, int p5);
    return {4'(p5), 4'(p4), 4'(p3), 4'(p2), 4'(p1)};
  endfunction

  task automatic t_reset();
    rst = 1'b1; qual_i = 5'h1F; prio_i = pk(1,2,3,4,5);
    revert_i = 1'b1; irq_en_i = 1'b1; fail_clr_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10", "reset sel", int'(sel_o), 0);
    check("R10", "reset rank", int'(rank_o), 0);
    check("R10", "reset fail", int'(fail_o), 0);
    rst = 1'b0; m_sel = '0; m_fail = 1'b0;
    step("R10");
  endtask

  task automatic t_ranking();
    revert_i = 1'b1;
    qual_i = 5'h1F; prio_i = pk(5,3,9,1,7);  step("R1");
    qual_i = 5'h17; prio_i = pk(5,3,9,1,7);  step("R3");
    qual_i = 5'h1F; prio_i = pk(4,0,0,2,0);  step("R1");
    qual_i = 5'h01; prio_i = pk(6,1,1,1,1);  step("R3");
  endtask

  task automatic t_tie();
    revert_i = 1'b1;
    qual_i = 5'h1F; prio_i = pk(8,2,2,8,2);  step("R2");
    qual_i = 5'h1D; prio_i = pk(3,3,3,3,3);  step("R2");
  endtask

  task automatic t_revert();
    revert_i = 1'b1;
    qual_i = 5'h04; prio_i = pk(1,2,6,4,5);  step("R4");
    qual_i = 5'h05;                           step("R4");
    check("R4", "switched to 1", int'(sel_o), 1);
  endtask

  task automatic t_hold();
    revert_i = 1'b0;
    qual_i = 5'h08; prio_i = pk(1,2,3,9,5);  step("R5");
    qual_i = 5'h1F;                           step("R5");
    check("R5", "kept 4", int'(sel_o), 4);
    prio_i = pk(1,1,1,9,1);                   step("R5");
  endtask

  task automatic t_switch();
    revert_i = 1'b0;
    qual_i = 5'h17;                           step("R6");
    check("R6", "moved to 1", int'(sel_o), 1);
    prio_i = pk(0,1,1,9,1);                   step("R6");
    check("R6", "moved to 2", int'(sel_o), 2);
  endtask

  task automatic t_fail();
    revert_i = 1'b1; irq_en_i = 1'b0;
    qual_i = 5'h00;                           step("R7");
    check("R8", "set", int'(fail_o), 1);
    check("R9", "masked irq", int'(irq_o), 0);
    irq_en_i = 1'b1; #1;
    check("R9", "irq on enable", int'(irq_o), 1);
    qual_i = 5'h02;                           step("R8");
    fail_clr_i = 1'b1; qual_i = 5'h00;        step("R8");
    check("R8", "set beats clear", int'(fail_o), 1);
    qual_i = 5'h02;                           step("R8");
    fail_clr_i = 1'b0;
    check("R8", "cleared", int'(fail_o), 0);
    step("R9");
  endtask

  initial begin
    t_reset();
    t_ranking();
    t_tie();
    t_revert();
    t_hold();
    t_switch();
    t_fail();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule